// File: doc/BRIEF.md
# Boot Loader and Reset-Vector Remap Controller

This block runs the power-on boot of a small system-on-chip. A boot strap, sampled once after power-on reset, picks one of two boot sources. In parallel-flash mode the CPU is let out of reset almost at once, and the chip-select 0 bank (the parallel flash) answers at address zero. The internal SRAM then stays at its normal base, 0x4000_0000.

In NAND mode the CPU stays in reset while a hardware copy engine reads the first 4 KB of the NAND device into the internal SRAM. The NAND device shares one 8-bit bus for commands, addresses and data, so every page is fetched with a fixed command and address sequence. After the last byte is stored, the CPU is released, and the SRAM answers at address zero so that the first fetch runs the copied code.

The copied bytes leave the block as a valid/ready byte stream with an SRAM address attached. A beat moves on a rising clock edge where valid and ready are both high. While valid is high and ready is low, the address and data stay fixed. The engine does not start the next NAND read strobe until the pending byte has been accepted, so back-pressure from the SRAM stalls the NAND bus and loses no data. The address decoder is combinational and acts on the CPU address in both modes.

Top module: `boot_remap_ctrl`

## Requirements
- R1: The boot strap (1 = NAND, 0 = parallel flash) is captured on the first rising clock edge after reset is released. Later changes of the strap have no effect on the decode or on the bus until the next reset.
- R2: In parallel-flash mode, boot_done rises after the second clock edge after reset release and cpu_rst_n rises after the third. No NAND write or read strobe is issued.
- R3: For each page, the NAND bus cycles come in a fixed order. First comes a command cycle (CLE high) with byte 0x00. Then come four address cycles (ALE high): two column bytes of 0x00, then the page index as row bytes, low byte first. Last comes a command cycle with byte 0x30. The device latches each byte on the rising edge of the write strobe. Pages are fetched in the order 0 to 7.
- R4: After the 0x30 command, the engine waits TWB cycles. It then waits for the ready/busy input to be high before it drives the first read strobe low. No read strobe falls while the device is busy.
- R5: The read strobe stays low for exactly RE_LO cycles and high for at least RE_HI cycles between reads. The data byte is taken from the bus as the strobe rises.
- R6: 4096 bytes (8 pages of 512) are sent on the SRAM write stream. Their addresses run from 0 to 4095 in order, and the byte at address A is NAND byte A. While valid is high and ready is low, the data and address hold, and no new read strobe starts.
- R7: cpu_rst_n and boot_done are low during reset. During the NAND copy, cpu_rst_n stays low. boot_done rises in the cycle after the last byte is accepted, and cpu_rst_n rises one cycle after boot_done. boot_done then stays high until the next reset.
- R8: In NAND mode, CPU addresses 0x0000_0000 to 0x0000_0FFF select the SRAM. Chip-select 0 is never selected, and other addresses select nothing.
- R9: In parallel-flash mode, addresses 0x0000_0000 to 0x07FF_FFFF select chip-select 0, and 0x4000_0000 to 0x4000_0FFF select the SRAM. Other addresses select nothing.
- R10: The SRAM select and the chip-select 0 select are never high together. The SRAM offset output equals CPU address bits 11:0.
- R11: The write and read strobes are never low together, and CLE and ALE are never high together. The bus output enable is high only during command and address cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| boot_nand_strap | input | 1 | Boot source strap, 1 = NAND |
| cpu_addr | input | 32 | CPU address to decode |
| cpu_sel_sram | output | 1 | Address hits the internal SRAM |
| cpu_sel_cs0 | output | 1 | Address hits chip-select 0 |
| cpu_sram_off | output | 12 | Byte offset inside the SRAM |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Bus value during command and address cycles |
| nand_io_oe | output | 1 | Bus output enable |
| nand_io_in | input | 8 | Bus value driven by the device |
| nand_rdy | input | 1 | Ready/busy, 1 = ready |
| sram_wr_valid | output | 1 | Write beat valid |
| sram_wr_ready | input | 1 | SRAM accepts the beat |
| sram_wr_addr | output | 12 | SRAM byte address |
| sram_wr_data | output | 8 | SRAM byte data |
| cpu_rst_n | output | 1 | CPU reset, active low |
| boot_done | output | 1 | Boot load finished, sticky |

## Verification
The assertions take for granted that the SRAM side follows the stream rules. They also assume the NAND device drops ready/busy within TWB cycles of the confirm command and keeps it low until the page is ready. Without that, the wait for ready would pass too early. The bench's device model drops ready/busy at the first falling edge after the confirm strobe rises and keeps it low for 20 cycles. The bench's SRAM model changes ready only at falling edges, so every accepted beat is one where valid and ready are both stable across the sampling edge.

// File: rtl/boot_pkg.sv
`timescale 1ns/1ps
package boot_pkg;
  typedef enum logic [3:0] {
    SQ_IDLE, SQ_CMD_RD, SQ_ADDR, SQ_CMD_GO,
    SQ_WAIT_BSY, SQ_WAIT_RDY, SQ_RE_LO, SQ_RE_HI, SQ_DONE
  } seq_state_t;

  localparam logic [7:0] NAND_CMD_READ    = 8'h00;
  localparam logic [7:0] NAND_CMD_CONFIRM = 8'h30;
endpackage

// File: rtl/boot_nand_seq.sv
`timescale 1ns/1ps
module boot_nand_seq import boot_pkg::*; #(
  parameter int PAGE_BYTES = 512,
  parameter int PAGES      = 8,
  parameter int COL_BYTES  = 2,
  parameter int ROW_BYTES  = 2,
  parameter int WE_LO      = 2,
  parameter int WE_HI      = 2,
  parameter int RE_LO      = 2,
  parameter int RE_HI      = 2,
  parameter int TWB        = 4,
  parameter int AW         = $clog2(PAGE_BYTES * PAGES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          nand_cle,
  output logic          nand_ale,
  output logic          nand_we_n,
  output logic          nand_re_n,
  output logic [7:0]    nand_io_out,
  output logic          nand_io_oe,
  input  logic [7:0]    nand_io_in,
  input  logic          nand_rdy,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data
);
  localparam int PGW   = (PAGES > 1) ? $clog2(PAGES) : 1;
  localparam int BW    = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;
  localparam int NADDR = COL_BYTES + ROW_BYTES;
  localparam int IW    = $clog2(NADDR + 1);
  localparam int ROWW  = 8 * ROW_BYTES;
  localparam int TW    = 8;

  seq_state_t     st;
  logic [TW-1:0]  tcnt;
  logic           hi_ph;
  logic [IW-1:0]  aidx;
  logic [PGW-1:0] page;
  logic [BW-1:0]  bcnt;
  logic [AW-1:0]  waddr;
  logic [7:0]     dreg;
  logic           pushed;
  logic           in_bus_wr;
  logic           fire;
  logic [ROWW-1:0] row_vec;
  logic [7:0]     addr_byte;

  assign in_bus_wr = (st == SQ_CMD_RD) || (st == SQ_ADDR) || (st == SQ_CMD_GO);
  assign nand_cle  = (st == SQ_CMD_RD) || (st == SQ_CMD_GO);
  assign nand_ale  = (st == SQ_ADDR);
  assign nand_io_oe = in_bus_wr;
  assign nand_we_n = !(in_bus_wr && !hi_ph);
  assign nand_re_n = (st != SQ_RE_LO);
  assign wr_valid  = (st == SQ_RE_HI) && !pushed;
  assign wr_addr   = waddr;
  assign wr_data   = dreg;
  assign fire      = wr_valid && wr_ready;
  assign row_vec   = ROWW'(page);

  // column bytes are zero, row bytes carry the page index low byte first
  always_comb begin
    addr_byte = 8'h00;
    for (int k = 0; k < ROW_BYTES; k++)
      if (aidx == IW'(COL_BYTES + k)) addr_byte = row_vec[8*k +: 8];
  end

  always_comb begin
    case (st)
      SQ_CMD_RD: nand_io_out = NAND_CMD_READ;
      SQ_CMD_GO: nand_io_out = NAND_CMD_CONFIRM;
      SQ_ADDR:   nand_io_out = addr_byte;
      default:   nand_io_out = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SQ_IDLE;
      tcnt   <= '0;
      hi_ph  <= 1'b0;
      aidx   <= '0;
      page   <= '0;
      bcnt   <= '0;
      waddr  <= '0;
      dreg   <= '0;
      pushed <= 1'b0;
    end else begin
      case (st)
        SQ_IDLE: if (start) begin
          st    <= SQ_CMD_RD;
          tcnt  <= '0;
          hi_ph <= 1'b0;
        end
        SQ_CMD_RD, SQ_ADDR, SQ_CMD_GO: begin
          if (!hi_ph) begin
            if (tcnt == TW'(WE_LO - 1)) begin
              hi_ph <= 1'b1;
              tcnt  <= '0;
            end else tcnt <= tcnt + 1'b1;
          end else if (tcnt == TW'(WE_HI - 1)) begin
            hi_ph <= 1'b0;
            tcnt  <= '0;
            if (st == SQ_CMD_RD) begin
              st   <= SQ_ADDR;
              aidx <= '0;
            end else if (st == SQ_ADDR) begin
              if (aidx == IW'(NADDR - 1)) st <= SQ_CMD_GO;
              else aidx <= aidx + 1'b1;
            end else st <= SQ_WAIT_BSY;
          end else tcnt <= tcnt + 1'b1;
        end
        SQ_WAIT_BSY: begin
          if (tcnt == TW'(TWB - 1)) begin
            st   <= SQ_WAIT_RDY;
            tcnt <= '0;
          end else tcnt <= tcnt + 1'b1;
        end
        SQ_WAIT_RDY: if (nand_rdy) begin
          st   <= SQ_RE_LO;
          tcnt <= '0;
        end
        SQ_RE_LO: begin
          if (tcnt == TW'(RE_LO - 1)) begin
            dreg   <= nand_io_in;
            pushed <= 1'b0;
            tcnt   <= '0;
            st     <= SQ_RE_HI;
          end else tcnt <= tcnt + 1'b1;
        end
        SQ_RE_HI: begin
          if (fire) begin
            pushed <= 1'b1;
            waddr  <= waddr + 1'b1;
          end
          if (tcnt != TW'(RE_HI - 1)) tcnt <= tcnt + 1'b1;
          if ((tcnt == TW'(RE_HI - 1)) && (pushed || fire)) begin
            tcnt <= '0;
            if (bcnt == BW'(PAGE_BYTES - 1)) begin
              bcnt <= '0;
              if (page == PGW'(PAGES - 1)) st <= SQ_DONE;
              else begin
                page <= page + 1'b1;
                st   <= SQ_CMD_RD;
              end
            end else begin
              bcnt <= bcnt + 1'b1;
              st   <= SQ_RE_LO;
            end
          end
        end
        default: st <= st;
      endcase
    end
  end
endmodule

// File: rtl/boot_addr_dec.sv
`timescale 1ns/1ps
module boot_addr_dec #(
  parameter int          SRAM_AW       = 12,
  parameter int          CS0_AW        = 27,
  parameter logic [31:0] NOR_SRAM_BASE = 32'h4000_0000
) (
  input  logic               nand_mode,
  input  logic [31:0]        cpu_addr,
  output logic               sel_sram,
  output logic               sel_cs0,
  output logic [SRAM_AW-1:0] sram_off
);
  localparam logic [31-SRAM_AW:0] NOR_HI = NOR_SRAM_BASE[31:SRAM_AW];

  logic low_win;
  logic nor_sram_win;
  logic cs0_win;

  assign low_win      = (cpu_addr[31:SRAM_AW] == '0);
  assign nor_sram_win = (cpu_addr[31:SRAM_AW] == NOR_HI);
  assign cs0_win      = (cpu_addr[31:CS0_AW] == '0);

  always_comb begin
    if (nand_mode) begin
      sel_sram = low_win;
      sel_cs0  = 1'b0;
    end else begin
      sel_sram = nor_sram_win;
      sel_cs0  = cs0_win;
    end
  end

  assign sram_off = cpu_addr[SRAM_AW-1:0];
endmodule

// File: rtl/boot_remap_ctrl.sv
`timescale 1ns/1ps
module boot_remap_ctrl #(
  parameter int          PAGE_BYTES    = 512,
  parameter int          PAGES         = 8,
  parameter int          COL_BYTES     = 2,
  parameter int          ROW_BYTES     = 2,
  parameter int          WE_LO         = 2,
  parameter int          WE_HI         = 2,
  parameter int          RE_LO         = 2,
  parameter int          RE_HI         = 2,
  parameter int          TWB           = 4,
  parameter int          CS0_AW        = 27,
  parameter logic [31:0] NOR_SRAM_BASE = 32'h4000_0000,
  parameter int          AW            = $clog2(PAGE_BYTES * PAGES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boot_nand_strap,
  input  logic [31:0]   cpu_addr,
  output logic          cpu_sel_sram,
  output logic          cpu_sel_cs0,
  output logic [AW-1:0] cpu_sram_off,
  output logic          nand_cle,
  output logic          nand_ale,
  output logic          nand_we_n,
  output logic          nand_re_n,
  output logic [7:0]    nand_io_out,
  output logic          nand_io_oe,
  input  logic [7:0]    nand_io_in,
  input  logic          nand_rdy,
  output logic          sram_wr_valid,
  input  logic          sram_wr_ready,
  output logic [AW-1:0] sram_wr_addr,
  output logic [7:0]    sram_wr_data,
  output logic          cpu_rst_n,
  output logic          boot_done
);
  localparam int TOTAL = PAGE_BYTES * PAGES;

  logic started;
  logic mode_nand;
  logic load_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started   <= 1'b0;
      mode_nand <= 1'b0;
    end else if (!started) begin
      started   <= 1'b1;
      mode_nand <= boot_nand_strap;
    end
  end

  assign load_last = sram_wr_valid && sram_wr_ready && (sram_wr_addr == AW'(TOTAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_done <= 1'b0;
      cpu_rst_n <= 1'b0;
    end else begin
      boot_done <= boot_done || (started && !mode_nand) || load_last;
      cpu_rst_n <= boot_done;
    end
  end

  boot_nand_seq #(
    .PAGE_BYTES(PAGE_BYTES), .PAGES(PAGES), .COL_BYTES(COL_BYTES), .ROW_BYTES(ROW_BYTES),
    .WE_LO(WE_LO), .WE_HI(WE_HI), .RE_LO(RE_LO), .RE_HI(RE_HI), .TWB(TWB), .AW(AW)
  ) i_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (started && mode_nand),
    .nand_cle    (nand_cle),
    .nand_ale    (nand_ale),
    .nand_we_n   (nand_we_n),
    .nand_re_n   (nand_re_n),
    .nand_io_out (nand_io_out),
    .nand_io_oe  (nand_io_oe),
    .nand_io_in  (nand_io_in),
    .nand_rdy    (nand_rdy),
    .wr_valid    (sram_wr_valid),
    .wr_ready    (sram_wr_ready),
    .wr_addr     (sram_wr_addr),
    .wr_data     (sram_wr_data)
  );

  boot_addr_dec #(
    .SRAM_AW(AW), .CS0_AW(CS0_AW), .NOR_SRAM_BASE(NOR_SRAM_BASE)
  ) i_dec (
    .nand_mode (mode_nand),
    .cpu_addr  (cpu_addr),
    .sel_sram  (cpu_sel_sram),
    .sel_cs0   (cpu_sel_cs0),
    .sram_off  (cpu_sram_off)
  );
endmodule

// File: rtl/boot_remap_chk.sv
`timescale 1ns/1ps
module boot_remap_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          nand_cle,
  input logic          nand_ale,
  input logic          nand_we_n,
  input logic          nand_re_n,
  input logic          nand_io_oe,
  input logic          sram_wr_valid,
  input logic          sram_wr_ready,
  input logic [AW-1:0] sram_wr_addr,
  input logic [7:0]    sram_wr_data,
  input logic          cpu_sel_sram,
  input logic          cpu_sel_cs0,
  input logic          cpu_rst_n,
  input logic          boot_done
);
  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));
  // R11
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
  // R11
  oe_vs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_io_oe);
  // R7
  cpu_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_done |-> !cpu_rst_n);
  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> boot_done);
  // R7
  release_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_n) |-> $past(boot_done));
  // R6
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_wr_valid && !sram_wr_ready) |=>
      (sram_wr_valid && $stable(sram_wr_addr) && $stable(sram_wr_data)));
  // R6
  no_write_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_n |-> !sram_wr_valid);
  // R10
  select_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_sel_sram && cpu_sel_cs0));
endmodule

bind boot_remap_ctrl boot_remap_chk #(.AW(AW)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .nand_cle      (nand_cle),
  .nand_ale      (nand_ale),
  .nand_we_n     (nand_we_n),
  .nand_re_n     (nand_re_n),
  .nand_io_oe    (nand_io_oe),
  .sram_wr_valid (sram_wr_valid),
  .sram_wr_ready (sram_wr_ready),
  .sram_wr_addr  (sram_wr_addr),
  .sram_wr_data  (sram_wr_data),
  .cpu_sel_sram  (cpu_sel_sram),
  .cpu_sel_cs0   (cpu_sel_cs0),
  .cpu_rst_n     (cpu_rst_n),
  .boot_done     (boot_done)
);

// File: tb/test_boot_remap_ctrl.sv
`timescale 1ns/1ps
module test_boot_remap_ctrl;
  localparam int RE_LO_T = 2;
  localparam int RE_HI_T = 2;
  localparam int TOTAL_T = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_nand_strap = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic        cpu_sel_sram, cpu_sel_cs0;
  logic [11:0] cpu_sram_off;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [7:0]  nand_io_out, nand_io_in;
  logic        nand_rdy;
  logic        sram_wr_valid;
  logic        sram_wr_ready = 1'b0;
  logic [11:0] sram_wr_addr;
  logic [7:0]  sram_wr_data;
  logic        cpu_rst_n, boot_done;

  int tests = 0;
  int failed = 0;

  always #10 clk = ~clk;

  boot_remap_ctrl i_boot_remap_ctrl (
    .clk(clk), .rst_n(rst_n), .boot_nand_strap(boot_nand_strap), .cpu_addr(cpu_addr),
    .cpu_sel_sram(cpu_sel_sram), .cpu_sel_cs0(cpu_sel_cs0), .cpu_sram_off(cpu_sram_off),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in),
    .nand_rdy(nand_rdy), .sram_wr_valid(sram_wr_valid), .sram_wr_ready(sram_wr_ready),
    .sram_wr_addr(sram_wr_addr), .sram_wr_data(sram_wr_data),
    .cpu_rst_n(cpu_rst_n), .boot_done(boot_done)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + (a >> 9) * 91) ^ 8'hA5);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // device and SRAM models, sampled on falling edges
  logic [7:0] mem [TOTAL_T];
  logic [7:0] abyte [4];
  int nadr, ptr, busy_left, exp_page, cmd_rd_cnt, cmd_go_cnt, seq_err;
  int strobe_cnt, busy_read_err, busy_seen, lo_len, hi_len, re_lo_err, re_hi_min;
  int wr_cnt, order_err, rst_viol;
  bit prev_we, prev_re, last_seen, exp_go;
  logic [7:0] lfsr;

  assign nand_rdy   = (busy_left == 0);
  assign nand_io_in = pat(ptr);

  always @(negedge clk) begin
    if (!rst_n) begin
      nadr = 0; ptr = 0; busy_left = 0; exp_page = 0; cmd_rd_cnt = 0; cmd_go_cnt = 0;
      seq_err = 0; strobe_cnt = 0; busy_read_err = 0; busy_seen = 0; lo_len = 0;
      hi_len = 0; re_lo_err = 0; re_hi_min = 1000; wr_cnt = 0; order_err = 0;
      rst_viol = 0; prev_we = 1; prev_re = 1; last_seen = 0; exp_go = 0;
      lfsr = 8'h5B; sram_wr_ready = 1'b0;
    end else begin
      if (busy_left > 0) busy_left--;
      if (!prev_we && nand_we_n) begin
        strobe_cnt++;
        if (nand_cle) begin
          if (nand_io_out == 8'h00) begin
            cmd_rd_cnt++;
            if (exp_go) seq_err++;
            exp_go = 1; nadr = 0;
          end else if (nand_io_out == 8'h30) begin
            cmd_go_cnt++;
            if (!exp_go || nadr != 4 || abyte[0] != 0 || abyte[1] != 0 ||
                ({abyte[3], abyte[2]} != 16'(exp_page))) seq_err++;
            exp_go = 0;
            ptr = int'({abyte[3], abyte[2]}) * 512;
            exp_page++;
            busy_left = 20; busy_seen++;
          end else seq_err++;
        end else if (nand_ale) begin
          if (nadr < 4) abyte[nadr] = nand_io_out;
          nadr++;
        end
      end
      if (!nand_re_n) begin
        if (prev_re) begin
          strobe_cnt++;
          if (busy_left != 0) busy_read_err++;
          if (hi_len < re_hi_min && hi_len != 0) re_hi_min = hi_len;
        end
        lo_len++;
      end else begin
        if (!prev_re) begin
          if (lo_len != RE_LO_T) re_lo_err++;
          ptr++; hi_len = 0;
        end
        lo_len = 0;
        if (ptr % 512 != 0) hi_len++;
      end
      prev_we = nand_we_n;
      prev_re = nand_re_n;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      sram_wr_ready = lfsr[0] | lfsr[1];
      if (sram_wr_valid && sram_wr_ready) begin
        if (int'(sram_wr_addr) != wr_cnt) order_err++;
        mem[sram_wr_addr] = sram_wr_data;
        wr_cnt++;
        if (wr_cnt == TOTAL_T) last_seen = 1;
      end
      if (!boot_done && cpu_rst_n) rst_viol++;
    end
  end

  // {nand_mode, addr, exp_sram, exp_cs0}
  localparam logic [34:0] VEC [12] = '{
    {1'b0, 32'h0000_0000, 1'b0, 1'b1},
    {1'b0, 32'h0000_0FFF, 1'b0, 1'b1},
    {1'b0, 32'h07FF_FFFF, 1'b0, 1'b1},
    {1'b0, 32'h0800_0000, 1'b0, 1'b0},
    {1'b0, 32'h4000_0000, 1'b1, 1'b0},
    {1'b0, 32'h4000_0ABC, 1'b1, 1'b0},
    {1'b0, 32'h4000_1000, 1'b0, 1'b0},
    {1'b1, 32'h0000_0000, 1'b1, 1'b0},
    {1'b1, 32'h0000_0F5A, 1'b1, 1'b0},
    {1'b1, 32'h0000_1000, 1'b0, 1'b0},
    {1'b1, 32'h4000_0000, 1'b0, 1'b0},
    {1'b1, 32'h07FF_FFFF, 1'b0, 1'b0}
  };

  task automatic run_vecs(input bit m);
    for (int i = 0; i < 12; i++) begin
      if (VEC[i][34] == m) begin
        @(negedge clk);
        cpu_addr = VEC[i][33:2];
        #2;
        chk(cpu_sel_sram == VEC[i][1], m ? "R8 sram select" : "R9 sram select",
            {31'd0, cpu_sel_sram}, {31'd0, VEC[i][1]});
        chk(cpu_sel_cs0 == VEC[i][0], m ? "R8 cs0 select" : "R9 cs0 select",
            {31'd0, cpu_sel_cs0}, {31'd0, VEC[i][0]});
        chk(cpu_sram_off == cpu_addr[11:0], "R10 sram offset",
            {20'd0, cpu_sram_off}, {20'd0, cpu_addr[11:0]});
      end
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; failed++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int bad;
    // ---------- parallel-flash boot ----------
    repeat (3) @(negedge clk);
    chk(!cpu_rst_n && !boot_done, "R7 reset state", {30'd0, cpu_rst_n, boot_done}, 0);
    chk(nand_we_n && nand_re_n && !sram_wr_valid, "R11 idle bus in reset",
        {29'd0, nand_we_n, nand_re_n, sram_wr_valid}, 32'h6);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!boot_done, "R2 done not yet", {31'd0, boot_done}, 0);
    @(negedge clk);
    chk(boot_done && !cpu_rst_n, "R2 done before release", {30'd0, boot_done, cpu_rst_n}, 2);
    @(negedge clk);
    chk(cpu_rst_n, "R2 cpu released", {31'd0, cpu_rst_n}, 1);
    run_vecs(1'b0);
    boot_nand_strap = 1'b1;
    repeat (40) @(negedge clk);
    cpu_addr = 32'h0;
    #2;
    chk(cpu_sel_cs0 && !cpu_sel_sram, "R1 strap change ignored", {30'd0, cpu_sel_cs0, cpu_sel_sram}, 2);
    chk(strobe_cnt == 0, "R2 no bus strobes", strobe_cnt, 0);

    // ---------- NAND boot ----------
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait (last_seen);
    @(negedge clk);
    chk(boot_done && !cpu_rst_n, "R7 done after last byte", {30'd0, boot_done, cpu_rst_n}, 2);
    @(negedge clk);
    chk(cpu_rst_n, "R7 release one cycle after done", {31'd0, cpu_rst_n}, 1);
    chk(rst_viol == 0, "R7 cpu held during copy", rst_viol, 0);
    chk(wr_cnt == TOTAL_T, "R6 byte count", wr_cnt, TOTAL_T);
    chk(order_err == 0, "R6 address order", order_err, 0);
    bad = 0;
    for (int a = 0; a < TOTAL_T; a++) if (mem[a] !== pat(a)) bad++;
    chk(bad == 0, "R6 copied data", bad, 0);
    chk(cmd_rd_cnt == 8 && cmd_go_cnt == 8, "R3 command count", cmd_rd_cnt * 16 + cmd_go_cnt, 136);
    chk(seq_err == 0, "R3 command and address order", seq_err, 0);
    chk(busy_seen == 8 && busy_read_err == 0, "R4 wait for ready", busy_read_err, 0);
    chk(re_lo_err == 0, "R5 read strobe low width", re_lo_err, 0);
    chk(re_hi_min >= RE_HI_T, "R5 read strobe high width", re_hi_min, RE_HI_T);
    boot_nand_strap = 1'b0;
    run_vecs(1'b1);
    repeat (50) @(negedge clk);
    cpu_addr = 32'h0000_0010;
    #2;
    chk(cpu_sel_sram && !cpu_sel_cs0, "R1 strap change ignored after NAND boot",
        {30'd0, cpu_sel_sram, cpu_sel_cs0}, 2);
    chk(boot_done && wr_cnt == TOTAL_T, "R7 done sticky, no further writes", wr_cnt, TOTAL_T);
    finish_run();
  end
endmodule